// File: doc/BRIEF.md
# Boot-Loop Map Fast-Initialization Sequencer

This block brings a power-switched magnetic-bubble storage module into service quickly. The slow path reads the good-loop map from the device itself. This block skips that read. It sends a fixed series of commands to the bubble controller, waiting for a ready handshake after each one. It then streams a stored map of usable minor loops out of an external nonvolatile table into the boot-loop register of the sense amplifier. The map has one bit per minor loop.

The series of commands runs in this order: reset/abort, purge, a short list of parametric-register bytes, and a masked boot-loop write. The streaming step follows. While the map streams, the block counts the bits that mark a loop as good. Some loops are spare and may be flagged unusable. The controller reads data correctly only when the count of good loops is exactly the required value. The block ends the run with a one-cycle done pulse if the count matches. Any other count raises a sticky error flag.

Top module: `bubble_fastinit_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `cmd_valid_o`, `boot_en_o`, `done_o` and `err_o` are all low.
- R2: A start strobe issues commands in this fixed order: abort (code 1), purge (code 2), five parameter writes (code 3), then the masked boot-loop write (code 4).
- R3: Each command is shown with a valid strobe lasting exactly one cycle. No further command is issued until `ctrl_ready_i` has been seen high after the previous one.
- R4: The five parameter writes carry the data bytes 0x10, 0x20, 0x01, 0x40, 0x8C on `cmd_data_o`, in that order. All other commands carry 0x00.
- R5: After the masked write, the map is fetched from ROM addresses 0 to 39 in order. The ROM has one cycle of read latency. The map is streamed as 320 bits on `boot_data_o`, each qualified by `boot_en_o`. Byte k supplies stream bits 8k to 8k+7, least significant bit first.
- R6: If exactly 272 streamed bits are 1, `done_o` pulses for one cycle as the block returns to idle, and `err_o` stays low.
- R7: Any other count of 1 bits (for example 271, 273 or 0) gives no done pulse. `err_o` rises and stays high while the block is idle.
- R8: A start strobe received while `busy_o` is high is ignored. The run in progress continues unchanged.
- R9: An accepted start clears `err_o` in the cycle after the start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe |
| ctrl_ready_i | input | 1 | Bubble controller ready for the next command |
| cmd_code_o | output | 4 | Command code |
| cmd_data_o | output | 8 | Parameter byte that goes with the command |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| rom_addr_o | output | 6 | Map ROM byte address |
| rom_data_i | input | 8 | Map ROM data, valid one cycle after the address |
| boot_data_o | output | 1 | Serial boot-loop map bit |
| boot_en_o | output | 1 | Qualifies `boot_data_o` |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: map loaded with the correct count |
| err_o | output | 1 | Sticky error: wrong good-loop count |

## Verification
The main map pattern mixes bytes 0xFE and 0x3F at irregular positions, so a wrong bit order or a wrong byte address changes the streamed bits. The count patterns 272, 271, 273 and all-zero separate an exact-match check from an off-by-one or a threshold check. A ready line held low shows that the sequencer really waits for the handshake. A start pulsed in the middle of a stream shows that a busy run cannot be restarted.

// File: rtl/bubble_fastinit_seq.sv
module bubble_fastinit_seq #(
  parameter int MAP_BITS   = 320,
  parameter int GOOD_LOOPS = 272,
  parameter int NPARAM     = 5,
  parameter logic [8*NPARAM-1:0] PARAM_TABLE = {8'h8C, 8'h40, 8'h01, 8'h20, 8'h10}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       ctrl_ready_i,
  output logic [3:0] cmd_code_o,
  output logic [7:0] cmd_data_o,
  output logic       cmd_valid_o,
  output logic [5:0] rom_addr_o,
  input  logic [7:0] rom_data_i,
  output logic       boot_data_o,
  output logic       boot_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  localparam int NBYTES = MAP_BITS / 8;
  localparam int NSTEP  = NPARAM + 3;
  localparam int SW     = $clog2(NSTEP);
  localparam int CW     = $clog2(MAP_BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_REQ, S_CAP, S_SHIFT} st_t;
  st_t st;

  logic [SW-1:0] step;
  logic [5:0]    addr;
  logic [7:0]    sh;
  logic [2:0]    bitc;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          done_r, err_r;

  assign cnt_nxt     = cnt + CW'(sh[0]);
  assign cmd_valid_o = (st == S_ISSUE);
  assign boot_en_o   = (st == S_SHIFT);
  assign boot_data_o = boot_en_o & sh[0];
  assign rom_addr_o  = addr;
  assign busy_o      = (st != S_IDLE);
  assign done_o      = done_r;
  assign err_o       = err_r;

  always_comb begin
    cmd_data_o = 8'h00;
    if (step == '0)
      cmd_code_o = 4'h1;
    else if (step == SW'(1))
      cmd_code_o = 4'h2;
    else if (step == SW'(NSTEP - 1))
      cmd_code_o = 4'h4;
    else begin
      cmd_code_o = 4'h3;
      cmd_data_o = PARAM_TABLE[8*(int'(step) - 2) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= '0;
      addr   <= '0;
      sh     <= '0;
      bitc   <= '0;
      cnt    <= '0;
      done_r <= 1'b0;
      err_r  <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE:
          if (start_i) begin
            err_r <= 1'b0;
            step  <= '0;
            st    <= S_ISSUE;
          end
        S_ISSUE: st <= S_WAIT;
        S_WAIT:
          if (ctrl_ready_i) begin
            if (step == SW'(NSTEP - 1)) begin
              addr <= '0;
              cnt  <= '0;
              st   <= S_REQ;
            end else begin
              step <= step + SW'(1);
              st   <= S_ISSUE;
            end
          end
        S_REQ: st <= S_CAP;
        S_CAP: begin
          sh   <= rom_data_i;
          bitc <= '0;
          st   <= S_SHIFT;
        end
        S_SHIFT: begin
          sh   <= sh >> 1;
          cnt  <= cnt_nxt;
          bitc <= bitc + 3'd1;
          if (bitc == 3'd7) begin
            if (addr == 6'(NBYTES - 1)) begin
              st     <= S_IDLE;
              done_r <= (cnt_nxt == CW'(GOOD_LOOPS));
              err_r  <= (cnt_nxt != CW'(GOOD_LOOPS));
            end else begin
              addr <= addr + 6'd1;
              st   <= S_REQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module bubble_fastinit_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic cmd_valid_o,
  input logic boot_en_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  // R3
  cmd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  // R3
  cmd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> busy_o);
  // R5
  stream_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_en_o |-> !cmd_valid_o);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6
  done_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!err_o && !busy_o));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !busy_o && !start_i) |=> err_o);
  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> !err_o);
endmodule

bind bubble_fastinit_seq bubble_fastinit_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_valid_o(cmd_valid_o),
  .boot_en_o(boot_en_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

// File: tb/bubble_fastinit_seq_tb.sv
module bubble_fastinit_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ctrl_ready_i = 1'b1;
  logic [3:0] cmd_code_o;
  logic [7:0] cmd_data_o;
  logic cmd_valid_o;
  logic [5:0] rom_addr_o;
  logic [7:0] rom_data_i = 8'h00;
  logic boot_data_o, boot_en_o, busy_o, done_o, err_o;

  always #4 clk = ~clk;

  bubble_fastinit_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_ready_i(ctrl_ready_i),
    .cmd_code_o(cmd_code_o), .cmd_data_o(cmd_data_o), .cmd_valid_o(cmd_valid_o),
    .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i), .boot_data_o(boot_data_o),
    .boot_en_o(boot_en_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  logic [7:0] rom [40];
  always @(posedge clk) rom_data_i <= (rom_addr_o < 6'd40) ? rom[rom_addr_o] : 8'h00;

  int errors = 0, checks = 0;
  int ncmd = 0, nbit = 0, ndone = 0;
  logic [3:0] cmd_log [16];
  logic [7:0] dat_log [16];
  logic       bit_log [512];

  always @(negedge clk) begin
    if (cmd_valid_o) begin
      if (ncmd < 16) begin cmd_log[ncmd] = cmd_code_o; dat_log[ncmd] = cmd_data_o; end
      ncmd = ncmd + 1;
    end
    if (boot_en_o) begin
      if (nbit < 512) bit_log[nbit] = boot_data_o;
      nbit = nbit + 1;
    end
    if (done_o) ndone = ndone + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_rom(input int good_bytes_variant);
    for (int k = 0; k < 40; k++) rom[k] = (k % 5 == 0) ? 8'h3F : 8'hFE;
    if (good_bytes_variant == 1) rom[1] = 8'hFC;
    if (good_bytes_variant == 2) rom[1] = 8'hFF;
    if (good_bytes_variant == 3) for (int k = 0; k < 40; k++) rom[k] = 8'h00;
  endtask

  task automatic clear_logs();
    ncmd = 0; nbit = 0; ndone = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 3000) begin @(negedge clk); n++; end
    chk(n < 3000, "R5 run completes", n, 3000);
    @(negedge clk);
  endtask

  task automatic check_cmds();
    logic [7:0] pexp [5] = '{8'h10, 8'h20, 8'h01, 8'h40, 8'h8C};
    bit code_ok = 1, data_ok = 1;
    chk(ncmd == 8, "R2 command count", ncmd, 8);
    if (ncmd == 8) begin
      for (int i = 0; i < 8; i++) begin
        int ec = (i == 0) ? 1 : (i == 1) ? 2 : (i == 7) ? 4 : 3;
        int ed = (i >= 2 && i <= 6) ? int'(pexp[i-2]) : 0;
        if (int'(cmd_log[i]) != ec) begin
          code_ok = 0; $display("FAIL R2 cmd %0d actual=%0d expected=%0d", i, cmd_log[i], ec);
        end
        if (int'(dat_log[i]) != ed) begin
          data_ok = 0; $display("FAIL R4 data %0d actual=%0h expected=%0h", i, dat_log[i], ed);
        end
      end
      checks += 2;
      if (!code_ok) errors++;
      if (!data_ok) errors++;
    end
  endtask

  task automatic check_stream();
    int bad = 0, first = -1;
    chk(nbit == 320, "R5 bit count", nbit, 320);
    for (int i = 0; i < 320 && i < nbit; i++)
      if (bit_log[i] != rom[i/8][i%8]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, "R5 bit order mismatch at index", first, -1);
  endtask

  task automatic t_reset();
    chk(!busy_o && !cmd_valid_o && !boot_en_o && !done_o && !err_o, "R1 idle after reset",
        {busy_o, cmd_valid_o, boot_en_o, done_o, err_o}, 0);
  endtask

  task automatic t_good();
    load_rom(0); clear_logs(); ctrl_ready_i = 1'b1;
    pulse_start(); wait_idle();
    check_cmds(); check_stream();
    chk(ndone == 1, "R6 done pulses", ndone, 1);
    chk(!err_o, "R6 err low", err_o, 0);
  endtask

  task automatic t_slow_ready();
    load_rom(0); clear_logs(); ctrl_ready_i = 1'b0;
    pulse_start();
    repeat (10) @(negedge clk);
    chk(ncmd == 1, "R3 waits for ready", ncmd, 1);
    ctrl_ready_i = 1'b1; @(negedge clk); ctrl_ready_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(ncmd == 2, "R3 one command per ready", ncmd, 2);
    ctrl_ready_i = 1'b1;
    wait_idle();
    check_cmds();
    chk(ndone == 1, "R6 done after slow ready", ndone, 1);
  endtask

  task automatic t_bad(input int variant, input string tag);
    load_rom(variant); clear_logs(); ctrl_ready_i = 1'b1;
    pulse_start(); wait_idle();
    chk(ndone == 0, {"R7 no done ", tag}, ndone, 0);
    chk(err_o, {"R7 err set ", tag}, err_o, 1);
    repeat (20) @(negedge clk);
    chk(err_o, {"R7 err held ", tag}, err_o, 1);
  endtask

  task automatic t_restart_clears();
    load_rom(0); clear_logs();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(!err_o, "R9 err cleared by start", err_o, 0);
    wait_idle();
    chk(ndone == 1 && !err_o, "R9 clean run after error", ndone, 1);
  endtask

  task automatic t_busy_start();
    load_rom(0); clear_logs();
    pulse_start();
    repeat (150) @(negedge clk);
    chk(busy_o, "R8 still busy before extra start", busy_o, 1);
    pulse_start();
    wait_idle();
    chk(ncmd == 8, "R8 no restart commands", ncmd, 8);
    chk(nbit == 320, "R8 stream unchanged length", nbit, 320);
    check_stream();
    chk(ndone == 1, "R8 single done", ndone, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    load_rom(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_slow_ready();
    t_bad(1, "271");
    t_restart_clears();
    t_bad(2, "273");
    t_bad(3, "zero");
    t_restart_clears();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule